// File: doc/BRIEF.md
# Interlaced Composite Sync Generator

This block derives the timing for a 2:1 interlaced raster from one master clock that runs at 32 times the line rate. A 16-state counter splits each line into two half-lines. A vertical counter steps once per half-line, so the two fields of a frame sit half a line apart. From these two counters the block produces an active-low mixed sync and three horizontal pulse trains. These are horizontal drive, horizontal clamp and horizontal processing blanking.

Around the start of each field the mixed sync switches from one pulse per line to the vertical interval. That interval is a group of narrow equalizing pulses at twice the line rate, then a group of serrated broad pulses, then a second equalizing group. Every edge of mixed sync is taken from a master-clock edge, so the horizontal phase stays intact through the vertical interval.

A mode input selects a 525-line or a 625-line frame. Two active-low inputs let an external source pull the vertical counter to a fixed point of the vertical interval. The block also exports the current line number, the half-line flag and the field flag, so that downstream decoders can build vertical drive and blanking.

Top module: `csync_gen`

## Requirements
- R1: A line lasts 32 clocks. The horizontal position p = 16*half_o + (clocks since the half-line began) runs 0..31. hdrive_n is low exactly when the position one clock earlier was 0 or 1.
- R2: mode_625 = 1 gives 625 lines per frame and mode_625 = 0 gives 525 lines. line_o counts 0..LINES-1 and then wraps to 0. field_o is 1 when 2*line_o + half_o >= LINES, which marks the second field.
- R3: Let k be the half-line index within the current field. Outside the vertical interval (k >= 18), msync_n is low one clock after positions p = 0 and p = 1, which is 2 clocks at each line start.
- R4: For k in 0..5 and k in 12..17, msync_n is low for 1 clock only, one clock after the first clock of each half-line. These are the equalizing pulses, 16 clocks apart.
- R5: For k in 6..11, msync_n is low one clock after half-line clocks 0..12 and high after clocks 13..15. No low run of msync_n lasts more than 13 clocks.
- R6: hclamp_n is low only one clock after position 2. hblank_n is low one clock after positions 0..5. hdrive_n low always falls inside hblank_n low.
- R7: vres_eq_n passes through two synchronizing flip-flops. While the synchronized value is low, the vertical counter is held at line 0, half 0, field 0, which is the first equalizing pulse. This input wins over vres_vs_n. The 16-clock half-line count keeps running.
- R8: While the synchronized vres_vs_n is low and vres_eq_n is not, the vertical counter is held at half-line 6 (line 3, half 0), which is the first broad pulse.
- R9: Synchronous active-high rst sets line 0, position 0, field 0 and clears both synchronizers to inactive. Every sync output reads high one clock after a clock edge with rst high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 32 per line |
| rst | input | 1 | Synchronous reset, active high |
| mode_625 | input | 1 | 1 selects 625 lines, 0 selects 525 lines |
| vres_eq_n | input | 1 | Asynchronous, active low: hold at first equalizing pulse |
| vres_vs_n | input | 1 | Asynchronous, active low: hold at first broad pulse |
| msync_n | output | 1 | Mixed sync, active low, registered |
| hdrive_n | output | 1 | Horizontal drive, 2 clocks, active low |
| hclamp_n | output | 1 | Horizontal clamp, 1 clock, active low |
| hblank_n | output | 1 | Horizontal processing blanking, 6 clocks, active low |
| line_o | output | 10 | Line number within the frame |
| half_o | output | 1 | 1 in the second half of a line |
| field_o | output | 1 | 1 during the second field |

## Verification
On every cycle the assertions check a set of local rules: the half-line counter wrap, the bound on the vertical count, that drive sits inside blanking, that clamp follows drive, the 13-clock limit on a mixed-sync low run, the two vertical presets and the reset values of the outputs. The full shape of the vertical interval can only be shown by the bench scenarios: equalizing at the right half-lines, broad pulses, and the half-line offset of the second field. The same holds for the frame wrap in both line modes, the two-flop delay of the preset inputs and the priority between them. For these the bench runs whole frames and checks the result clock by clock against its own line-and-position model.

// File: rtl/csync_pkg.sv
package csync_pkg;

  // Half-line index measured from the start of the current field.
  function automatic int unsigned field_half(int unsigned vhalf, int unsigned lines);
    return (vhalf >= lines) ? vhalf - lines : vhalf;
  endfunction

  // Mixed-sync low decision for field half-line k and half-line clock hc.
  function automatic logic mixed_sync_low(int unsigned k, logic odd_half, int unsigned hc,
                                          int unsigned eq_n, int unsigned br_low,
                                          int unsigned hs_w);
    if (k < eq_n || (k >= 2*eq_n && k < 3*eq_n)) return hc == 0;
    if (k < 2*eq_n) return hc < br_low;
    return !odd_half && (hc < hs_w);
  endfunction

  function automatic logic in_window(int unsigned pos, int unsigned start, int unsigned width);
    return (pos >= start) && (pos < start + width);
  endfunction

endpackage

// File: rtl/csync_sync2.sv
module csync_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= din[i];
        s2 <= s1;
      end
    end
    assign dout[i] = s2;
  end
endmodule

// File: rtl/csync_hcount.sv
module csync_hcount #(
  parameter int HALF_CLKS = 16,
  localparam int HW = $clog2(HALF_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hcnt,
  output logic          half_end
);
  assign half_end = (hcnt == HW'(HALF_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst)           hcnt <= '0;
    else if (half_end) hcnt <= '0;
    else               hcnt <= hcnt + 1'b1;
  end

  assert_half_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (hcnt == HW'(HALF_CLKS - 1)) |=> (hcnt == '0));
  assert_half_step_R1: assert property (@(posedge clk) disable iff (rst)
    (hcnt != HW'(HALF_CLKS - 1)) |=> (hcnt == $past(hcnt) + 1'b1));
endmodule

// File: rtl/csync_vcount.sv
module csync_vcount #(
  parameter int VW        = 11,
  parameter int LINES_STD = 525,
  parameter int LINES_ALT = 625,
  parameter int VS_HALF   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_625,
  input  logic          step,
  input  logic          hold_eq,
  input  logic          hold_vs,
  output logic [VW-1:0] vhalf
);
  localparam logic [VW-1:0] LAST_STD = VW'(2*LINES_STD - 1);
  localparam logic [VW-1:0] LAST_ALT = VW'(2*LINES_ALT - 1);
  localparam logic [VW-1:0] VS_POS   = VW'(VS_HALF);

  logic [VW-1:0] last_w;
  assign last_w = mode_625 ? LAST_ALT : LAST_STD;

  always_ff @(posedge clk) begin
    if (rst)          vhalf <= '0;
    else if (hold_eq) vhalf <= '0;
    else if (hold_vs) vhalf <= VS_POS;
    else if (step)    vhalf <= (vhalf >= last_w) ? '0 : vhalf + 1'b1;
  end

  assert_frame_bound_R2: assert property (@(posedge clk) disable iff (rst)
    vhalf <= last_w);
  assert_eq_preset_R7: assert property (@(posedge clk) disable iff (rst)
    hold_eq |=> (vhalf == '0));
  assert_vs_preset_R8: assert property (@(posedge clk) disable iff (rst)
    (hold_vs && !hold_eq) |=> (vhalf == VS_POS));
endmodule

// File: rtl/csync_decode.sv
module csync_decode
  import csync_pkg::*;
#(
  parameter int HALF_CLKS = 16,
  parameter int VW        = 11,
  parameter int LINES_STD = 525,
  parameter int LINES_ALT = 625,
  parameter int EQ_COUNT  = 6,
  parameter int BROAD_LOW = 13,
  parameter int HSYNC_W   = 2,
  parameter int HDRIVE_W  = 2,
  parameter int CLAMP_POS = 2,
  parameter int CLAMP_W   = 1,
  parameter int HBLANK_W  = 6,
  localparam int HW = $clog2(HALF_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_625,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vhalf,
  output logic          msync_n,
  output logic          hdrive_n,
  output logic          hclamp_n,
  output logic          hblank_n
);
  int unsigned lines_w, pos_w, k_w;
  logic ms_low, hd_on, cl_on, hb_on;

  always_comb begin
    lines_w = mode_625 ? LINES_ALT : LINES_STD;
    pos_w   = 32'({vhalf[0], hcnt});
    k_w     = field_half(32'(vhalf), lines_w);
    ms_low  = mixed_sync_low(k_w, vhalf[0], 32'(hcnt), EQ_COUNT, BROAD_LOW, HSYNC_W);
    hd_on   = in_window(pos_w, 0, HDRIVE_W);
    cl_on   = in_window(pos_w, CLAMP_POS, CLAMP_W);
    hb_on   = in_window(pos_w, 0, HBLANK_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msync_n  <= 1'b1;
      hdrive_n <= 1'b1;
      hclamp_n <= 1'b1;
      hblank_n <= 1'b1;
    end else begin
      msync_n  <= !ms_low;
      hdrive_n <= !hd_on;
      hclamp_n <= !cl_on;
      hblank_n <= !hb_on;
    end
  end

  // Length of the current low run of mixed sync, for the broad-pulse check.
  logic [HW:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || msync_n)             low_run <= '0;
    else if (low_run != '1)         low_run <= low_run + 1'b1;
  end

  assert_broad_max_R5: assert property (@(posedge clk) disable iff (rst)
    low_run <= (HW+1)'(BROAD_LOW));
  assert_drive_in_blank_R6: assert property (@(posedge clk) disable iff (rst)
    !hdrive_n |-> !hblank_n);
  assert_clamp_after_drive_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hdrive_n) |-> !hclamp_n);
  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (msync_n && hdrive_n && hclamp_n && hblank_n));
endmodule

// File: rtl/csync_gen.sv
module csync_gen #(
  parameter int HALF_CLKS = 16,
  parameter int LINES_STD = 525,
  parameter int LINES_ALT = 625,
  parameter int EQ_COUNT  = 6,
  parameter int BROAD_LOW = 13,
  parameter int HSYNC_W   = 2,
  parameter int HDRIVE_W  = 2,
  parameter int CLAMP_POS = 2,
  parameter int CLAMP_W   = 1,
  parameter int HBLANK_W  = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mode_625,
  input  logic                          vres_eq_n,
  input  logic                          vres_vs_n,
  output logic                          msync_n,
  output logic                          hdrive_n,
  output logic                          hclamp_n,
  output logic                          hblank_n,
  output logic [$clog2(LINES_ALT)-1:0]  line_o,
  output logic                          half_o,
  output logic                          field_o
);
  localparam int HW = $clog2(HALF_CLKS);
  localparam int VW = $clog2(2*LINES_ALT);

  logic [1:0]    vres_s;
  logic [HW-1:0] hcnt;
  logic          half_end;
  logic [VW-1:0] vhalf;
  logic          hold_eq, hold_vs;

  csync_sync2 #(.W(2)) u_sync (
    .clk(clk), .rst(rst), .din({vres_vs_n, vres_eq_n}), .dout(vres_s));

  assign hold_eq = !vres_s[0];
  assign hold_vs = !vres_s[1];

  csync_hcount #(.HALF_CLKS(HALF_CLKS)) u_hcount (
    .clk(clk), .rst(rst), .hcnt(hcnt), .half_end(half_end));

  csync_vcount #(.VW(VW), .LINES_STD(LINES_STD), .LINES_ALT(LINES_ALT),
                 .VS_HALF(EQ_COUNT)) u_vcount (
    .clk(clk), .rst(rst), .mode_625(mode_625), .step(half_end),
    .hold_eq(hold_eq), .hold_vs(hold_vs), .vhalf(vhalf));

  csync_decode #(.HALF_CLKS(HALF_CLKS), .VW(VW), .LINES_STD(LINES_STD),
                 .LINES_ALT(LINES_ALT), .EQ_COUNT(EQ_COUNT), .BROAD_LOW(BROAD_LOW),
                 .HSYNC_W(HSYNC_W), .HDRIVE_W(HDRIVE_W), .CLAMP_POS(CLAMP_POS),
                 .CLAMP_W(CLAMP_W), .HBLANK_W(HBLANK_W)) u_decode (
    .clk(clk), .rst(rst), .mode_625(mode_625), .hcnt(hcnt), .vhalf(vhalf),
    .msync_n(msync_n), .hdrive_n(hdrive_n), .hclamp_n(hclamp_n), .hblank_n(hblank_n));

  assign line_o  = vhalf[VW-1:1];
  assign half_o  = vhalf[0];
  assign field_o = vhalf >= (mode_625 ? VW'(LINES_ALT) : VW'(LINES_STD));
endmodule

// File: tb/csync_gen_tb_top.sv
module csync_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1, mode_625 = 1'b0, vres_eq_n = 1'b1, vres_vs_n = 1'b1;
  logic msync_n, hdrive_n, hclamp_n, hblank_n, half_o, field_o;
  logic [9:0] line_o;

  always #10 clk = ~clk;  // 50 MHz

  csync_gen dut_i (
    .clk(clk), .rst(rst), .mode_625(mode_625), .vres_eq_n(vres_eq_n),
    .vres_vs_n(vres_vs_n), .msync_n(msync_n), .hdrive_n(hdrive_n),
    .hclamp_n(hclamp_n), .hblank_n(hblank_n), .line_o(line_o),
    .half_o(half_o), .field_o(field_o));

  typedef struct {
    logic ms, hd, cl, hb, hf, fd;
    int   ln;
    string tag_ms, tag_h, tag_v;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // Reference model: line number and 0..31 position, plus two-stage input delay.
  int m_ln = 0, m_p = 0;
  logic e1 = 1'b1, e2 = 1'b1, v1 = 1'b1, v2 = 1'b1;

  always @(posedge clk) begin
    exp_t e;
    int L, a, k, hp;
    logic fe, fv;
    L = mode_625 ? 625 : 525;
    if (rst) begin
      e.ms = 1; e.hd = 1; e.cl = 1; e.hb = 1;
      e.tag_ms = "R9"; e.tag_h = "R9"; e.tag_v = "R9";
      m_ln = 0; m_p = 0; e1 = 1; e2 = 1; v1 = 1; v2 = 1;
    end else begin
      a  = 2*m_ln + ((m_p >= 16) ? 1 : 0);
      k  = (a >= L) ? a - L : a;
      hp = m_p % 16;
      if (k < 6 || (k >= 12 && k < 18)) begin e.ms = !(hp == 0); e.tag_ms = "R4"; end
      else if (k < 12) begin e.ms = !(hp < 13); e.tag_ms = "R5"; end
      else begin e.ms = !(m_p < 2); e.tag_ms = "R3"; end
      e.hd = !(m_p < 2);
      e.cl = !(m_p == 2);
      e.hb = !(m_p < 6);
      e.tag_h = "R6";
      fe = !e2; fv = !v2;
      e2 = e1; e1 = vres_eq_n; v2 = v1; v1 = vres_vs_n;
      if (fe) begin
        m_ln = 0; m_p = (m_p + 1) % 16; e.tag_v = "R7";
      end else if (fv) begin
        m_ln = 3; m_p = (m_p + 1) % 16; e.tag_v = "R8";
      end else begin
        m_p++;
        if (m_p == 32) begin
          m_p = 0; m_ln++;
          if (m_ln == L) m_ln = 0;
        end
        e.tag_v = "R2";
      end
    end
    e.ln = m_ln;
    e.hf = (m_p >= 16);
    e.fd = ((2*m_ln + ((m_p >= 16) ? 1 : 0)) >= L);
    exp_q.push_back(e);
  end

  task automatic check(string name, string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, name, cycles, act, expv);
    end
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check("msync_n", e.tag_ms, int'(msync_n), int'(e.ms));
      check("hdrive_n", (e.tag_h == "R9") ? "R9" : "R1", int'(hdrive_n), int'(e.hd));
      check("hclamp_n", e.tag_h, int'(hclamp_n), int'(e.cl));
      check("hblank_n", e.tag_h, int'(hblank_n), int'(e.hb));
      check("line_o", e.tag_v, int'(line_o), e.ln);
      check("half_o", (e.tag_v == "R9") ? "R9" : "R1", int'(half_o), int'(e.hf));
      check("field_o", e.tag_v, int'(field_o), int'(e.fd));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected at most 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R2 R3 R4 R5: one full 525-line frame and its wrap
    repeat (17200) @(negedge clk);
    // R7: equalizing preset mid-field
    vres_eq_n = 0; repeat (40) @(negedge clk); vres_eq_n = 1;
    repeat (600) @(negedge clk);
    // R8: broad-pulse preset
    vres_vs_n = 0; repeat (40) @(negedge clk); vres_vs_n = 1;
    repeat (600) @(negedge clk);
    // R7 priority over R8
    vres_eq_n = 0; vres_vs_n = 0; repeat (30) @(negedge clk);
    vres_eq_n = 1; vres_vs_n = 1;
    repeat (600) @(negedge clk);
    // R9 then R2 in 625-line mode
    rst = 1; mode_625 = 1; repeat (3) @(negedge clk); rst = 0;
    repeat (20300) @(negedge clk);
    vres_vs_n = 0; repeat (20) @(negedge clk); vres_vs_n = 1;
    repeat (400) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule